// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-word SPI master controlled through a 32-bit register port. Software first selects the clock mode, the word length and the bit-rate divisor. It then writes a tag to the transmit control register. The tag holds a 2-bit chip-select channel and an end-of-frame flag. Writing the transmit buffer starts one transfer. The controller asserts the chosen active-low chip select and shifts the word out MSB first on `mosi`. At the same time it shifts a word of the same length in from `miso`.

When the last bit is done, the received word goes into the receive buffer. The tag the word was sent under is kept beside it, so software can compare the two. The chip select stays asserted between words until a word tagged end-of-frame completes. This lets a multi-word frame reach one peripheral without the select dropping.

Busy, transmit-empty, receive-full and a latched word-done flag can all be read. An interrupt line is raised from any status bit whose enable bit is set.

Top module: `spim_ctrl`

## Requirements
- R1: After reset every `cs_n` line is high, service status bit 0 (busy) reads 0, interrupt status reads 0x08 (only transmit-empty set) and `irq` is 0.
- R2: A write to the transmit buffer (0x10) while configuration bit 31 (enable) and bit 11 (master) are 1 and the bus is idle starts a transfer. Busy then reads 1, interrupt status bit 3 (transmit-empty) reads 0, and `cs_n[ch]` goes low, where ch is transmit control (0x0C) bits 1:0.
- R3: Configuration bits 1:0 hold a code n that gives a word of 8*(n+1) bits. The low bits of the transmit word go out MSB first. The received word reads right-aligned from the receive buffer (0x18), with its upper bits zero.
- R4: Configuration bit 14 (polarity) sets the idle level of `sclk`. With bit 13 (phase) at 0, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With phase at 1 the two edges swap roles.
- R5: Each `sclk` half period lasts the number of bus clocks held in the bit-rate register (0x08, bits 7:0). A value of 0 acts as 1.
- R6: Transmit control bit 2 is the end-of-frame flag. If it is 1, all chip selects go high when the word ends. If it is 0, the chip select stays low after the word.
- R7: Receive control (0x14) bits 1:0 give the channel, and bit 2 gives the end-of-frame flag, that the last received word was sent with.
- R8: At the end of a word, interrupt status bit 2 (receive-full) is set, busy clears and transmit-empty sets.
- R9: A read of the receive buffer clears receive-full.
- R10: A write to the transmit buffer is ignored while the block is disabled or a transfer is in progress.
- R11: Interrupt status bit 4 latches word completion. Writing a 1 to bit 4 of interrupt status clears it. `irq` is the OR of interrupt status bits 7:0 ANDed with the interrupt enable register (0x2C).
- R12: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_rd | input | 1 | Read qualifier for the strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The shift engine is driven by a peripheral model that follows the programmed polarity and phase. The model is tried with all four clock modes, all four word lengths and divisors of 0, 1, 2 and 3.

Distinct data patterns are sent in each direction. A swapped edge, a bit-order error or a wrong alignment therefore shows up as a wrong word rather than an accidental match. One 24-bit word is received from an all-ones input, which separates correct masking from upper bits leaking through.

A frame of two words with end-of-frame clear and then set tells apart holding the chip select and releasing it. Channel changes between words show whether the received tag follows the word it was sent with.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int SPIM_DW  = 32;
    localparam int SPIM_NCS = 4;
    localparam int SPIM_CHW = $clog2(SPIM_NCS);
    localparam int SPIM_AW  = 6;

    localparam logic [SPIM_AW-1:0] A_CFG = 6'h00;
    localparam logic [SPIM_AW-1:0] A_SVC = 6'h04;
    localparam logic [SPIM_AW-1:0] A_DIV = 6'h08;
    localparam logic [SPIM_AW-1:0] A_TXC = 6'h0C;
    localparam logic [SPIM_AW-1:0] A_TXB = 6'h10;
    localparam logic [SPIM_AW-1:0] A_RXC = 6'h14;
    localparam logic [SPIM_AW-1:0] A_RXB = 6'h18;
    localparam logic [SPIM_AW-1:0] A_IST = 6'h28;
    localparam logic [SPIM_AW-1:0] A_IEN = 6'h2C;

    typedef struct packed {
        logic       en;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] len;
    } cfg_t;

    typedef struct packed {
        logic                eof;
        logic [SPIM_CHW-1:0] ch;
    } tag_t;

    function automatic logic [7:0] word_bits(input logic [1:0] code);
        return ({6'd0, code} + 8'd1) << 3;
    endfunction

    function automatic logic [SPIM_NCS-1:0] ch_onehot(input logic [SPIM_CHW-1:0] ch);
        return SPIM_NCS'(1) << ch;
    endfunction
endpackage

// File: rtl/spim_tick.sv
module spim_tick
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    assign half = (div == '0) ? DIV_W'(1) : div;
    assign tick = run && (cnt_q == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + DIV_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && half > DIV_W'(1)) |=> !tick); // R5
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int DW = SPIM_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                tick,
    input  cfg_t                cfg,
    input  tag_t                tag_in,
    input  logic [DW-1:0]       tx_in,
    input  logic                miso,
    output logic                busy,
    output logic                done,
    output logic [DW-1:0]       rx_word,
    output tag_t                tag_out,
    output logic                sclk,
    output logic                mosi,
    output logic [SPIM_NCS-1:0] cs
);
    localparam int CNT_W = $clog2(2 * DW + 2);

    logic [CNT_W-1:0] edge_q, lim_q;
    logic [DW-1:0]    out_sh, rx_sh, aligned;
    logic [7:0]       nb;
    logic             cpha_q, lead, sample;

    assign nb      = word_bits(cfg.len);
    assign aligned = tx_in << (8'(DW) - nb);
    assign lead    = ~edge_q[0];
    assign sample  = lead ^ cpha_q;
    assign done    = busy && tick && (edge_q == lim_q);
    assign rx_word = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; sclk <= 1'b0; mosi <= 1'b0;
            out_sh <= '0; rx_sh <= '0; edge_q <= '0; lim_q <= '0;
            cpha_q <= 1'b0; tag_out <= '0; cs <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            sclk    <= cfg.cpol;
            edge_q  <= '0;
            lim_q   <= CNT_W'({1'b0, nb} << 1);
            cpha_q  <= cfg.cpha;
            tag_out <= tag_in;
            cs      <= ch_onehot(tag_in.ch);
            rx_sh   <= '0;
            if (!cfg.cpha) begin
                mosi   <= aligned[DW-1];
                out_sh <= aligned << 1;
            end else begin
                out_sh <= aligned;
            end
        end else if (busy && tick) begin
            if (edge_q == lim_q) begin
                busy <= 1'b0;
                if (tag_out.eof) cs <= '0;
            end else begin
                sclk   <= ~sclk;
                edge_q <= edge_q + CNT_W'(1);
                if (sample) begin
                    rx_sh <= {rx_sh[DW-2:0], miso};
                end else begin
                    mosi   <= out_sh[DW-1];
                    out_sh <= out_sh << 1;
                end
            end
        end else if (!busy) begin
            sclk <= cfg.cpol;
        end
    end

    AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs)); // R12
    AST_START_SELECTS: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cs != '0)); // R2
    AST_EOF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (done && tag_out.eof) |=> (cs == '0)); // R6
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !tag_out.eof) |=> $stable(cs)); // R6
    AST_TAG_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(tag_out)); // R7
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DW    = SPIM_DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [SPIM_AW-1:0] bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic [DW-1:0]      rx_word,
    input  tag_t               rx_tag_in,
    output cfg_t               cfg,
    output logic [DIV_W-1:0]   div,
    output tag_t               txc,
    output logic               start,
    output logic               irq
);
    logic          wr_hit, rd_hit, rx_full, done_lat;
    logic [DW-1:0] rx_data;
    tag_t          rx_tag;
    logic [7:0]    ien, istat;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && bus_rd;
    assign start  = wr_hit && (bus_addr == A_TXB) && cfg.en && cfg.master && !busy;
    assign istat  = {3'd0, done_lat, ~busy, rx_full, 2'd0};
    assign irq    = |(istat & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0; div <= '0; txc <= '0; ien <= '0;
            rx_full <= 1'b0; done_lat <= 1'b0; rx_data <= '0; rx_tag <= '0;
        end else begin
            if (wr_hit) begin
                case (bus_addr)
                    A_CFG: cfg <= '{en: bus_wdata[31], master: bus_wdata[11],
                                    cpol: bus_wdata[14], cpha: bus_wdata[13],
                                    len: bus_wdata[1:0]};
                    A_DIV: div <= bus_wdata[DIV_W-1:0];
                    A_TXC: txc <= bus_wdata[$bits(tag_t)-1:0];
                    A_IEN: ien <= bus_wdata[7:0];
                    default: ;
                endcase
            end
            if (done)                                         rx_full <= 1'b1;
            else if (rd_hit && bus_addr == A_RXB)             rx_full <= 1'b0;
            if (done)                                         done_lat <= 1'b1;
            else if (wr_hit && bus_addr == A_IST && bus_wdata[4]) done_lat <= 1'b0;
            if (done) begin
                rx_data <= rx_word;
                rx_tag  <= rx_tag_in;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = {cfg.en, 16'd0, cfg.cpol, cfg.cpha, 1'b0,
                                  cfg.master, 9'd0, cfg.len};
            A_SVC:   bus_rdata = {31'd0, busy};
            A_DIV:   bus_rdata = 32'(div);
            A_TXC:   bus_rdata = 32'(txc);
            A_RXC:   bus_rdata = 32'(rx_tag);
            A_RXB:   bus_rdata = 32'(rx_data);
            A_IST:   bus_rdata = {24'd0, istat};
            A_IEN:   bus_rdata = {24'd0, ien};
            default: bus_rdata = '0;
        endcase
    end

    AST_RXFULL_SET: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_full); // R8
    AST_RXFULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && bus_addr == A_RXB && !done) |=> !rx_full); // R9
    AST_DONE_LATCH: assert property (@(posedge clk) disable iff (rst)
        done |=> (done_lat && !busy)); // R11
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_n
);
    cfg_t                cfg;
    tag_t                txc, rx_tag;
    logic [DIV_W-1:0]    div;
    logic                start, busy, done, tick;
    logic [SPIM_DW-1:0]  rx_word;
    logic [SPIM_NCS-1:0] cs;

    assign cs_n = ~cs;

    spim_regs #(.DIV_W(DIV_W), .DW(SPIM_DW)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .rx_word(rx_word), .rx_tag_in(rx_tag),
        .cfg(cfg), .div(div), .txc(txc), .start(start), .irq(irq)
    );

    spim_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run(busy), .div(div), .tick(tick)
    );

    spim_shift #(.DW(SPIM_DW)) u_shift (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .cfg(cfg),
        .tag_in(txc), .tx_in(bus_wdata[SPIM_DW-1:0]), .miso(miso),
        .busy(busy), .done(done), .rx_word(rx_word), .tag_out(rx_tag),
        .sclk(sclk), .mosi(mosi), .cs(cs)
    );
endmodule

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
    logic clk = 1'b0, rst = 1'b1;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, sclk, mosi, miso;
    logic [3:0] cs_n;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [32:0] sl_sh = '0;
    logic [31:0] mosi_cap = '0;
    logic m_cpol = 0, m_cpha = 0, s_prev = 0;

    always #10 clk = ~clk;
    assign miso = sl_sh[32];

    spim_ctrl uut (.clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n));

    // peripheral model: samples mosi and shifts miso on the mode's edges
    always @(negedge clk) begin
        if (cs_n != 4'hF && sclk != s_prev) begin
            if ((sclk != m_cpol) ^ m_cpha) mosi_cap = {mosi_cap[30:0], mosi};
            else                           sl_sh = sl_sh << 1;
        end
        s_prev = sclk;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(6'h04, s);
            if (s[0] == 1'b0) return;
        end
    endtask

    task automatic half_period(output int n);
        logic p;
        p = sclk;
        while (sclk == p) @(negedge clk);
        p = sclk; n = 0;
        while (sclk == p) begin @(negedge clk); n++; end
    endtask

    function automatic logic [31:0] cfg_word(logic en, logic cpol, logic cpha, logic [1:0] lc);
        return {en, 16'd0, cpol, cpha, 1'b0, 1'b1, 9'd0, lc};
    endfunction

    typedef struct packed {
        logic cpol, cpha; logic [1:0] lc; logic [7:0] div;
        logic [1:0] ch; logic eof; logic [31:0] tx, mw, exp_rx;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{0,0,2'd0,8'd1,2'd0,1,32'h000000A5,32'h0000003C,32'h0000003C},
        '{0,1,2'd0,8'd2,2'd1,1,32'h0000005A,32'h000000C3,32'h000000C3},
        '{1,0,2'd1,8'd3,2'd2,1,32'h00001234,32'h0000BEEF,32'h0000BEEF},
        '{1,1,2'd3,8'd0,2'd3,1,32'hDEADBEEF,32'h13579BDF,32'h13579BDF},
        '{0,0,2'd2,8'd1,2'd1,0,32'h00ABCDEF,32'h000F1E2D,32'h000F1E2D},
        '{0,0,2'd2,8'd1,2'd1,1,32'hFF00FF00,32'hFFFFFFFF,32'h00FFFFFF},
        '{0,0,2'd0,8'd1,2'd2,0,32'h00000081,32'h0000007E,32'h0000007E},
        '{0,0,2'd0,8'd1,2'd2,1,32'h00000000,32'h00000080,32'h00000080}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, msk;
        int nb, hp;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(6'h04, d); check("R1 busy", d, 0);
        rd(6'h28, d); check("R1 istat", d, 32'h08);
        check("R1 cs_n", {28'd0, cs_n}, 32'hF);
        check("R1 irq", {31'd0, irq}, 0);

        // R10 disabled: no transfer
        wr(6'h00, cfg_word(0, 0, 0, 0));
        wr(6'h10, 32'h55);
        rd(6'h04, d); check("R10 disabled busy", d, 0);
        check("R10 disabled cs_n", {28'd0, cs_n}, 32'hF);

        // main table
        foreach (VECS[i]) begin
            nb = 8 * (VECS[i].lc + 1);
            msk = (nb == 32) ? 32'hFFFFFFFF : ((32'd1 << nb) - 1);
            m_cpol = VECS[i].cpol; m_cpha = VECS[i].cpha;
            wr(6'h00, cfg_word(1, VECS[i].cpol, VECS[i].cpha, VECS[i].lc));
            wr(6'h08, {24'd0, VECS[i].div});
            wr(6'h0C, {29'd0, VECS[i].eof, VECS[i].ch});
            sl_sh = VECS[i].cpha ? {1'b0, VECS[i].mw << (32 - nb)}
                                 : {VECS[i].mw << (32 - nb), 1'b0};
            mosi_cap = '0;
            wr(6'h10, VECS[i].tx);
            wait_idle();
            check("R3 R4 mosi word", mosi_cap & msk, VECS[i].tx & msk);
            rd(6'h18, d); check("R3 R4 rx word", d, VECS[i].exp_rx);
            rd(6'h14, d); check("R7 rx tag", d, {29'd0, VECS[i].eof, VECS[i].ch});
            check("R6 cs_n after word", {28'd0, cs_n},
                  VECS[i].eof ? 32'hF : {28'd0, ~(4'd1 << VECS[i].ch)});
            check("R4 sclk idle", {31'd0, sclk}, {31'd0, VECS[i].cpol});
            rd(6'h28, d); check("R8 R9 istat after read", d & 32'h0C, 32'h08);
        end

        // R2 start, R10 write while busy
        m_cpol = 0; m_cpha = 0;
        wr(6'h00, cfg_word(1, 0, 0, 0));
        wr(6'h08, 32'd4);
        wr(6'h0C, 32'h6);
        sl_sh = '0; mosi_cap = '0;
        wr(6'h10, 32'h3C);
        rd(6'h04, d); check("R2 busy", d, 1);
        rd(6'h28, d); check("R2 tx empty clear", d & 32'h08, 0);
        check("R2 cs_n", {28'd0, cs_n}, 32'hB);
        wr(6'h10, 32'hFF);
        wait_idle();
        rd(6'h28, d); check("R8 done flags", d & 32'h0C, 32'h0C);
        repeat (40) @(negedge clk);
        rd(6'h04, d); check("R10 no second transfer", d, 0);
        check("R10 first word kept", mosi_cap & 32'hFF, 32'h3C);

        // R5 divider
        wr(6'h08, 32'd3);
        wr(6'h10, 32'h0F);
        half_period(hp); check("R5 div 3", hp, 3);
        wait_idle();
        wr(6'h08, 32'd0);
        wr(6'h10, 32'hF0);
        half_period(hp); check("R5 div 0", hp, 1);
        wait_idle();

        // R11 latched done and interrupt, R9 receive-full clear
        rd(6'h28, d); check("R11 istat", d, 32'h1C);
        check("R11 irq masked", {31'd0, irq}, 0);
        wr(6'h2C, 32'h10); check("R11 irq done", {31'd0, irq}, 1);
        wr(6'h28, 32'h10);
        rd(6'h28, d); check("R11 done cleared", d & 32'h10, 0);
        check("R11 irq after clear", {31'd0, irq}, 0);
        wr(6'h2C, 32'h04); check("R11 irq rx full", {31'd0, irq}, 1);
        rd(6'h18, d);
        rd(6'h28, d); check("R9 rx full cleared", d & 32'h04, 0);
        check("R9 irq drops", {31'd0, irq}, 0);
        check("R12 all released", {28'd0, cs_n}, 32'hF);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule